// File: doc/BRIEF.md
# Receive Half-Word Packer with Residual Byte Pop

This block sits between a byte-serial receiver and software. Bytes arriving from the deserializer are paired into 16-bit half-words, first byte high and second byte low, and written into a small receive FIFO. Software reads the FIFO through a 32-bit data word. Only the low 16 bits of that word carry data.

A transfer can end on an odd byte. That byte then waits in a holding register as a residual, and software can force it into the FIFO with a pop strobe. Two status flags support a short handshake. The residual-valid flag drops when the residual is consumed by a pop, and it also drops when a new transmission starts. The residual-frame flag drops only when a new transmission starts. After popping, software reads the flags. The pair valid=0, frame=1 means the popped entry is good. Any other pair means new traffic raced the pop. In that case software discards the entry, and the held byte reappears as the upper byte of the next half-word.

Top module: `rx_half_packer`

## Requirements
- R1: With no byte held, a byte is stored as the upper half of a pair. The next byte completes the pair, and {first, second} is written to the FIFO in that cycle. Reads return the entries in write order, with bits 31:16 of `rd_data` equal to zero.
- R2: When a byte is stored in an empty holding register, `st_res_vld` and `st_res_frm` are both 1 after that edge. When a byte completes a pair, both flags are 0 after that edge.
- R3: A pop strobe while `st_res_vld` is 1 writes {held byte, 8'h00} to the FIFO and empties the holding register. After that edge the flags read valid=0, frame=1.
- R4: A new-transmission pulse without a byte in the same cycle clears both flags.
- R5: A pop strobe while a byte is held but `st_res_vld` is 0 still writes {held byte, 8'h00}. The flags stay 0,0 and the byte stays held, so the next byte yields {held byte, new byte}.
- R6: A pop strobe with no byte held causes no FIFO write and leaves the flags unchanged.
- R7: A write while the FIFO holds `FIFO_DEPTH` entries is dropped, and the level does not change. `st_overflow` goes to 1 and stays 1 until reset. A dropped pop still advances the flags as in R3.
- R8: After reset the FIFO is empty, the level is 0, and all three status flags are 0.
- R9: A pop strobe in the same cycle as `rx_byte_vld` or `rx_new_xfer` is disregarded.
- R10: `rd_en` while the FIFO is empty has no effect on the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_vld | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_new_xfer | input | 1 | Start of a new transmission |
| pop_wr | input | 1 | Bus write to the residual pop location |
| rd_en | input | 1 | Consume the FIFO head entry |
| rd_data | output | 32 | FIFO head entry, zero-extended |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH entries |
| fifo_level | output | LVL_W | Number of stored entries |
| st_res_vld | output | 1 | Residual-valid flag |
| st_res_frm | output | 1 | Residual-frame flag |
| st_overflow | output | 1 | Sticky dropped-write flag |

## Verification
The main sequence runs through five cases:
- a plain even transfer;
- an odd transfer closed by a clean pop;
- a pop that loses the race to a new transmission;
- a pop with nothing held;
- pops that collide with a byte or with a transfer start.

Each case has a distinct flag pair and level at every step, and a distinct entry in the drained FIFO. That separates a good residual entry from a race marker, and it separates a re-used held byte from a lost one. A fill-to-full run then shows which writes are dropped and confirms that the overflow flag persists.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int BUS_W  = 32;

  typedef struct packed {
    logic vld;
    logic frm;
  } res_flags_t;

  // Two received bytes, earlier one in the upper half.
  function automatic logic [HALF_W-1:0] join_pair(input logic [BYTE_W-1:0] first,
                                                  input logic [BYTE_W-1:0] second);
    return {first, second};
  endfunction

  // Residual entry: held byte on top, zero fill below.
  function automatic logic [HALF_W-1:0] residual_entry(input logic [BYTE_W-1:0] held);
    return {held, {BYTE_W{1'b0}}};
  endfunction

  // Bus view of a half-word: upper bits read as zero.
  function automatic logic [BUS_W-1:0] widen(input logic [HALF_W-1:0] h);
    return {{(BUS_W-HALF_W){1'b0}}, h};
  endfunction
endpackage

// File: rtl/rxp_pair_packer.sv
module rxp_pair_packer
  import rxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              new_xfer,
  input  logic              pop_req,
  output logic              push_en,
  output logic [HALF_W-1:0] push_data,
  output logic              res_vld,
  output logic              res_frm
);
  logic              hold_q;
  logic [BYTE_W-1:0] hold_byte;
  res_flags_t        flags_q;

  // Named internal events
  logic pair_done, pop_blocked, pop_fire, pop_consume;

  assign pair_done   = byte_vld & hold_q;
  assign pop_blocked = byte_vld | new_xfer;
  assign pop_fire    = pop_req & hold_q & ~pop_blocked;
  assign pop_consume = pop_fire & flags_q.vld;

  assign push_en   = pair_done | pop_fire;
  assign push_data = pair_done ? join_pair(hold_byte, byte_data)
                               : residual_entry(hold_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      hold_byte <= '0;
    end else if (byte_vld) begin
      hold_q <= ~hold_q;
      if (!hold_q) hold_byte <= byte_data;
    end else if (pop_consume) begin
      hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (byte_vld) begin
      flags_q <= hold_q ? res_flags_t'(2'b00) : res_flags_t'(2'b11);
    end else if (new_xfer) begin
      flags_q <= '0;
    end else if (pop_consume) begin
      flags_q.vld <= 1'b0;
    end
  end

  assign res_vld = flags_q.vld;
  assign res_frm = flags_q.frm;

  a_r2_hold_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !hold_q) |=> (res_vld && res_frm));
  a_r2_pair_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && hold_q) |=> (!res_vld && !res_frm && !hold_q));
  a_r3_pop_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    pop_consume |=> (!res_vld && res_frm && !hold_q));
  a_r4_new_xfer_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (new_xfer && !byte_vld) |=> (!res_vld && !res_frm));
  a_r5_race_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !res_vld) |=> (hold_q && $stable(hold_byte)));
  a_r6_idle_pop_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !hold_q && !byte_vld && !new_xfer) |=> $stable(flags_q));
  a_r2_valid_implies_frame: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> res_frm);
endmodule

// File: rtl/rxp_sync_fifo.sv
module rxp_sync_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic [CW-1:0]     count,
  output logic              drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              wr_ok, rd_ok;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign wr_ok   = wr_req & ~full;
  assign rd_ok   = rd_req & ~empty;
  assign drop    = wr_req & full;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= next_ptr(wptr);
      if (rd_ok) rptr <= next_ptr(rptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_req) |=> (full && $stable(wptr)));
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req) |=> (empty && $stable(rptr)));
endmodule

// File: rtl/rx_half_packer.sv
module rx_half_packer
  import rxp_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_byte_vld,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_new_xfer,
  input  logic              pop_wr,
  input  logic              rd_en,
  output logic [BUS_W-1:0]  rd_data,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              st_res_vld,
  output logic              st_res_frm,
  output logic              st_overflow
);
  logic              push_en;
  logic [HALF_W-1:0] push_data;
  logic [HALF_W-1:0] head;
  logic              wr_dropped;

  rxp_pair_packer packer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (rx_byte_vld),
    .byte_data (rx_byte),
    .new_xfer  (rx_new_xfer),
    .pop_req   (pop_wr),
    .push_en   (push_en),
    .push_data (push_data),
    .res_vld   (st_res_vld),
    .res_frm   (st_res_frm)
  );

  rxp_sync_fifo #(.DATA_W(HALF_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (push_en),
    .wr_data (push_data),
    .rd_req  (rd_en),
    .rd_data (head),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .count   (fifo_level),
    .drop    (wr_dropped)
  );

  assign rd_data = widen(head);

  always_ff @(posedge clk) begin
    if (!rst_n)          st_overflow <= 1'b0;
    else if (wr_dropped) st_overflow <= 1'b1;
  end

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st_overflow |=> st_overflow);
  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |=> st_overflow);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:HALF_W] == '0);
endmodule

// File: tb/rx_half_packer_tb_top.sv
`timescale 1ns/1ps
module rx_half_packer_tb_top;
  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NV    = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_byte_vld, rx_new_xfer, pop_wr, rd_en;
  logic [7:0]  rx_byte;
  logic [31:0] rd_data;
  logic        fifo_empty, fifo_full, st_res_vld, st_res_frm, st_overflow;
  logic [LW-1:0] fifo_level;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  rx_half_packer #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_new_xfer(rx_new_xfer), .pop_wr(pop_wr), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_level(fifo_level), .st_res_vld(st_res_vld), .st_res_frm(st_res_frm),
    .st_overflow(st_overflow)
  );

  // Entry: [16] new_xfer [15] byte_vld [14] pop [13:6] byte
  //        [5] expected valid [4] expected frame [3:0] expected level
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,8'hA1,1'b1,1'b1,4'd0},  // R2 hold
    {1'b0,1'b1,1'b0,8'hB2,1'b0,1'b0,4'd1},  // R1 pair
    {1'b0,1'b1,1'b0,8'hC3,1'b1,1'b1,4'd1},  // R2
    {1'b0,1'b0,1'b1,8'h00,1'b0,1'b1,4'd2},  // R3 clean pop
    {1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,4'd2},  // R4
    {1'b0,1'b1,1'b0,8'hD4,1'b1,1'b1,4'd2},  // R2
    {1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,4'd2},  // R4
    {1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,4'd3},  // R5 raced pop
    {1'b0,1'b1,1'b0,8'hE5,1'b0,1'b0,4'd4},  // R5 reuse
    {1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,4'd4},  // R6 idle pop
    {1'b0,1'b1,1'b1,8'h66,1'b1,1'b1,4'd4},  // R9 pop with byte
    {1'b1,1'b0,1'b1,8'h00,1'b0,1'b0,4'd4},  // R9 pop with new xfer
    {1'b0,1'b1,1'b0,8'h77,1'b0,1'b0,4'd5}   // R1
  };

  localparam logic [15:0] DRAIN [5] = '{16'hA1B2, 16'hC300, 16'hD400, 16'hD4E5, 16'h6677};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FIFO check FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic nx, input logic bv, input logic [7:0] d,
                      input logic pp, input logic rd);
    @(negedge clk);
    rx_new_xfer = nx; rx_byte_vld = bv; rx_byte = d; pop_wr = pp; rd_en = rd;
    @(negedge clk);
    rx_new_xfer = 1'b0; rx_byte_vld = 1'b0; pop_wr = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("watchdog FAIL timeout: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_byte_vld = 1'b0; rx_new_xfer = 1'b0; pop_wr = 1'b0;
    rd_en = 1'b0; rx_byte = '0;
    do_reset();
    // R8 reset state
    chk({28'd0, fifo_empty, st_res_vld, st_res_frm, st_overflow}, 32'h8, "R8 flags");
    chk(32'(fifo_level), 0, "R8 level");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16], VEC[i][15], VEC[i][13:6], VEC[i][14], 1'b0);
      chk({30'd0, st_res_vld, st_res_frm}, {30'd0, VEC[i][5], VEC[i][4]},
          $sformatf("R2/R3/R4/R5/R6/R9 flags step %0d", i));
      chk(32'(fifo_level), 32'(VEC[i][3:0]), $sformatf("R1/R5/R6/R9 level step %0d", i));
    end

    for (int i = 0; i < 5; i++) begin
      chk(rd_data, {16'h0, DRAIN[i]}, $sformatf("R1/R3/R5 entry %0d", i));
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    end
    chk(32'(fifo_empty), 1, "R1 drained empty");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk(32'(fifo_level), 0, "R10 read on empty");
    chk(32'(st_overflow), 0, "R7 no overflow yet");

    // Fill to full, then overflow (R7)
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, 1'b1, 8'(8'h10 + 2 * i), 1'b0, 1'b0);
      step(1'b0, 1'b1, 8'(8'h11 + 2 * i), 1'b0, 1'b0);
    end
    chk(32'(fifo_full), 1, "R7 full");
    chk(32'(st_overflow), 0, "R7 full not overflow");
    step(1'b0, 1'b1, 8'h55, 1'b0, 1'b0);
    step(1'b0, 1'b1, 8'h56, 1'b0, 1'b0);
    chk(32'(fifo_level), DEPTH, "R7 level held");
    chk(32'(st_overflow), 1, "R7 overflow set");
    step(1'b0, 1'b1, 8'h57, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    chk({30'd0, st_res_vld, st_res_frm}, 32'h1, "R7 dropped pop flags");
    chk(32'(fifo_level), DEPTH, "R7 pop dropped");
    chk(rd_data, 32'h0000_1011, "R7 head intact");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk(32'(fifo_level), DEPTH - 1, "R7 read after full");
    chk(rd_data, 32'h0000_1213, "R1 order");
    chk(32'(st_overflow), 1, "R7 overflow sticky");

    do_reset();
    chk({28'd0, fifo_empty, st_res_vld, st_res_frm, st_overflow}, 32'h8, "R8 second reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule